// File: doc/BRIEF.md
# Binary-Field Karatsuba Multiplier with Sparse Reduction

This block multiplies two elements of the binary field GF(2^m), each given as an m-bit polynomial. Bit i of an operand is the coefficient of x^i. The product is formed without carries, by Karatsuba splitting that recurses down to single-bit AND leaves. The (2m−1)-bit raw product is then folded back to m bits modulo a fixed field polynomial F(x) = x^m + L(x), where L(x) holds the low-order terms. In practice F is a trinomial or a pentanomial.

Splitting uses the half width h = (m+1)/2. The low part takes bits [h−1:0] and the high part takes the rest. When m is odd, the high part is zero-extended to h bits before it is added to the low part. Three sub-products are formed at each level: low×low, high×high and (low⊕high)×(low⊕high). The middle term is the third sub-product XORed with the other two. All of these are combined with XOR at offsets 0, h and 2h.

The whole multiply and reduce is one combinational path. A single register captures the result. A caller pulses `start` with the operands present. The field product appears on `result` in the next cycle, flagged by a one-cycle `done`. It is held there until the next start.

Top module: `gf2m_kara_mult`

## Requirements
- R1: While `rst_n` is low, and at the first sampling point after it, `result` is zero and `done` is low.
- R2: `done` is high in exactly the cycles that follow a cycle in which `start` was high at the clock edge.
- R3: On an edge where `start` is high, `result` is loaded with (x·y mod F). Here x·y is the carry-free product over GF(2), and F = x^WIDTH + POLY_LOW, where bit k of POLY_LOW is the coefficient of x^k. The default is WIDTH 16 and POLY_LOW 16'h002B, so F = x^16+x^5+x^3+x+1.
- R4: On an edge where `start` is low, `result` keeps its value, and any change on `x` or `y` has no effect.
- R5: A zero operand on either side gives a zero result.
- R6: When `y` is 1 (only bit 0 set), `result` equals `x`.
- R7: Reduction also covers folds that land at or above degree m again. With the default F, 16'h8000·16'h0002 gives 16'h002B, and all-ones operands give the fully reduced value.
- R8: When `start` is held high on consecutive cycles with new operands each cycle, every cycle's operands produce their own result one cycle later, with `done` staying high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture the product of the current operands |
| x | input | WIDTH | First operand polynomial, bit k is coefficient of x^k |
| y | input | WIDTH | Second operand polynomial |
| result | output | WIDTH | Reduced field product, held between starts |
| done | output | 1 | One-cycle flag that a new result is on `result` |

## Verification
The properties assume that `start`, `x` and `y` are never unknown at a clock edge. They also assume that `start` may be high on any cycle, including back to back. They do not assume that operands hold still between starts, so the hold property really does compare a stable `result` against moving inputs. The bench meets these assumptions by driving every input on the falling edge from a defined value, with `start` low during reset. It also deliberately changes `x` and `y` while `start` is low.

// File: rtl/gf2kara_pkg.sv
package gf2kara_pkg;
  // Strobes issued by the sequencer to the datapath.
  typedef struct packed {
    logic capture;
  } kara_strobe_t;
endpackage

// File: rtl/kara_node.sv
// One level of the carry-free Karatsuba tree. It recurses on itself until
// the operands are one bit wide.
module kara_node #(
  parameter int W = 16
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-2:0] p
);
  generate
    if (W == 1) begin : g_leaf
      assign p = a & b;
    end else begin : g_split
      localparam int H  = (W + 1) / 2;  // low half width
      localparam int HU = W - H;        // high half width (H-1 when W odd)
      localparam int PW = 2 * W - 1;

      logic [H-1:0]    aLo, bLo, aSum, bSum;
      logic [HU-1:0]   aHi, bHi;
      logic [2*H-2:0]  zLo, zMid;
      logic [2*HU-2:0] zHi;
      logic [PW-1:0]   eLo, eHi, eMid;

      assign aLo  = a[H-1:0];
      assign bLo  = b[H-1:0];
      assign aHi  = a[W-1:H];
      assign bHi  = b[W-1:H];
      // The high half is zero-padded to H bits before it is added.
      assign aSum = aLo ^ H'(aHi);
      assign bSum = bLo ^ H'(bHi);

      kara_node #(.W(H))  u_lo  (.a(aLo),  .b(bLo),  .p(zLo));
      kara_node #(.W(HU)) u_hi  (.a(aHi),  .b(bHi),  .p(zHi));
      kara_node #(.W(H))  u_mid (.a(aSum), .b(bSum), .p(zMid));

      assign eLo  = PW'(zLo);
      assign eHi  = PW'(zHi);
      assign eMid = PW'(zMid);

      // Combine as P = Zlo + Zhi*x^(2H) + (Zmid ^ Zlo ^ Zhi)*x^H.
      assign p = eLo ^ (eHi << (2 * H)) ^ ((eMid ^ eLo ^ eHi) << H);
    end
  endgenerate
endmodule

// File: rtl/gf2_fold.sv
// Reduces a (2W-1)-bit raw product modulo x^W + LOW. Folding goes from the
// top degree downwards, so terms that land at or above W again are caught.
module gf2_fold #(
  parameter int           W   = 16,
  parameter logic [W-1:0] LOW = 16'h002B
) (
  input  logic [2*W-2:0] prod,
  output logic [W-1:0]   rem
);
  localparam int PW = 2 * W - 1;

  logic [PW-1:0] acc;

  always_comb begin
    acc = prod;
    for (int d = PW - 1; d >= W; d--) begin
      if (acc[d]) begin
        acc = acc ^ (PW'(1) << d) ^ (PW'(LOW) << (d - W));
      end
    end
  end

  assign rem = acc[W-1:0];
endmodule

// File: rtl/kara_datapath.sv
module kara_datapath
  import gf2kara_pkg::*;
#(
  parameter int               WIDTH    = 16,
  parameter logic [WIDTH-1:0] POLY_LOW = 16'h002B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  kara_strobe_t     strobe,
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  output logic [WIDTH-1:0] result
);
  logic [2*WIDTH-2:0] rawProd;
  logic [WIDTH-1:0]   reduced;
  logic [WIDTH-1:0]   resultQ;

  kara_node #(.W(WIDTH)) u_tree (.a(x), .b(y), .p(rawProd));

  gf2_fold #(.W(WIDTH), .LOW(POLY_LOW)) u_fold (.prod(rawProd), .rem(reduced));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resultQ <= '0;
    else if (strobe.capture) resultQ <= reduced;
  end

  assign result = resultQ;
endmodule

// File: rtl/kara_ctrl.sv
module kara_ctrl
  import gf2kara_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  output kara_strobe_t strobe,
  output logic         done
);
  logic doneQ;

  always_comb begin
    strobe         = '0;
    strobe.capture = start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) doneQ <= 1'b0;
    else        doneQ <= start;
  end

  assign done = doneQ;
endmodule

// File: rtl/gf2m_kara_mult.sv
module gf2m_kara_mult
  import gf2kara_pkg::*;
#(
  parameter int               WIDTH    = 16,
  parameter logic [WIDTH-1:0] POLY_LOW = 16'h002B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  output logic [WIDTH-1:0] result,
  output logic             done
);
  kara_strobe_t strobe;

  kara_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .strobe(strobe), .done(done)
  );

  kara_datapath #(.WIDTH(WIDTH), .POLY_LOW(POLY_LOW)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .x(x), .y(y), .result(result)
  );
endmodule

// File: rtl/gf2m_kara_mult_chk.sv
module gf2m_kara_mult_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [WIDTH-1:0] x,
  input logic [WIDTH-1:0] y,
  input logic [WIDTH-1:0] result,
  input logic             done
);
  // R2: a start is always followed by done
  a_r2_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  // R2: no done without a start in the previous cycle
  a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);

  // R4: the result holds when no start is seen
  a_r4_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(result));

  // R5: a zero operand gives zero
  a_r5_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (x == '0 || y == '0)) |=> (result == '0));

  // R6: multiplying by one returns the other operand
  a_r6_unit_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (start && y == WIDTH'(1)) |=> (result == $past(x)));
endmodule

bind gf2m_kara_mult gf2m_kara_mult_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .x(x), .y(y),
  .result(result), .done(done)
);

// File: tb/gf2m_kara_mult_tb.sv
`timescale 1ns/1ps
module gf2m_kara_mult_tb;
  localparam int             W    = 16;
  localparam logic [W-1:0]   POLY = 16'h002B;
  localparam int             NVEC = 8;
  localparam logic [2*W-1:0] VEC [NVEC] = '{
    {16'h1234, 16'h5678}, {16'hFFFF, 16'hFFFF}, {16'h8000, 16'h8000},
    {16'h0001, 16'hBEEF}, {16'hA5A5, 16'h5A5A}, {16'hFFFF, 16'h0001},
    {16'h8001, 16'hC003}, {16'h7FFF, 16'hFFFE}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] x = '0;
  logic [W-1:0] y = '0;
  logic [W-1:0] result;
  logic         done;

  int total = 0;
  int failed = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  gf2m_kara_mult #(.WIDTH(W), .POLY_LOW(POLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .x(x), .y(y),
    .result(result), .done(done)
  );

  // Horner-style reference: shift by x and reduce at every step.
  function automatic logic [W-1:0] refMul(logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] r = '0;
    logic top;
    for (int i = W - 1; i >= 0; i--) begin
      top = r[W-1];
      r = r << 1;
      if (top) r = r ^ POLY;
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  endtask

  // Single operation: drive, capture, then sample the result and done.
  task automatic mulOp(string req, logic [W-1:0] a, logic [W-1:0] b);
    @(negedge clk);
    x = a; y = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({req, " done"}, W'(done), W'(1));
    chk({req, " product"}, result, refMul(a, b));
  endtask

  initial begin
    #(4 * 200000);
    total++; failed++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [W-1:0] held;
    logic [W-1:0] pa, pb;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 reset result", result, '0);
    chk("R1 reset done", W'(done), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release result", result, '0);
    chk("R2 no done without start", W'(done), '0);

    // R3, R7: table of vectors
    for (int i = 0; i < NVEC; i++)
      mulOp("R3 table", VEC[i][2*W-1:W], VEC[i][W-1:0]);

    // R7: a fold that lands exactly on x^16
    mulOp("R7 x^15*x", 16'h8000, 16'h0002);
    chk("R7 x^16 value", result, 16'h002B);
    mulOp("R7 all ones", 16'hFFFF, 16'hFFFF);

    // R5: zero operands
    mulOp("R5 zero y", 16'hDEAD, 16'h0000);
    chk("R5 zero y value", result, '0);
    mulOp("R5 zero x", 16'h0000, 16'hBEEF);
    chk("R5 zero x value", result, '0);

    // R6: multiply by one
    mulOp("R6 unit", 16'hC0DE, 16'h0001);
    chk("R6 unit value", result, 16'hC0DE);

    // R4: operands change without a start, so result and done must not move
    held = result;
    @(negedge clk);
    x = 16'h1357; y = 16'h2468;
    @(negedge clk);
    x = 16'hFFFF; y = 16'h8000;
    @(negedge clk);
    chk("R4 held result", result, held);
    chk("R4 no done", W'(done), '0);

    // R3: random operations
    for (int k = 0; k < 200; k++)
      mulOp("R3 random", W'($urandom), W'($urandom));

    // R8: back-to-back starts
    pa = '0; pb = '0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (k > 0) begin
        chk("R8 pipelined product", result, refMul(pa, pb));
        chk("R8 done stays high", W'(done), W'(1));
      end
      pa = W'($urandom); pb = W'($urandom);
      x = pa; y = pb; start = 1'b1;
    end
    @(negedge clk);
    start = 1'b0;
    chk("R8 last product", result, refMul(pa, pb));
    @(negedge clk);
    chk("R2 done drops", W'(done), '0);

    summary();
  end
endmodule